// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column address for every data beat of one SDRAM read or write burst. A mode word, written through a strobe, holds a burst length code and an ordering bit. The same setting serves reads and writes. A start strobe with a starting column launches a burst. The block then puts out one column per clock, each with a valid flag, and marks the final beat with a last flag.

The beats stay inside an aligned block whose size is the burst length, and they wrap inside it. In sequential order the offset counts up from the start position. In interleaved order each offset is the start position XOR the beat number. A terminate input cuts a burst short. A start request seen on the final beat chains the next burst with no gap. A reserved length code raises an error flag, and no burst starts while the flag is set.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_valid, beat_last and mode_err are 0 and col_out is 0. The stored mode is length code 001 (2 beats) with sequential order.
- R2: Length code 001 gives bursts of 2 beats, code 010 gives 4 beats and code 011 gives 8 beats. The code is taken from mode_len_code when mode_wr is high at a clock edge.
- R3: Codes 000 and 100 to 111 are reserved. mode_err reads 1 from the edge that stores such a code, and start is ignored while mode_err is 1. Storing a valid code clears mode_err at that edge.
- R4: With a burst length of 2^k, bits k and above of col_out equal the same bits of start_col on every beat of the burst.
- R5: With mode_order = 0 (sequential), beat i carries the low k bits (start + i) mod 2^k. A start offset of 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R6: With mode_order = 1 (interleaved), beat i carries the low k bits start XOR i. A start offset of 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R7: beat_last is 1 only on the final beat of a burst, and only for that one cycle.
- R8: If term is 1 at an edge while a beat that is not the final one is shown, beat_valid is 0 from that edge on.
- R9: A start seen at the edge that ends the final beat makes beat 0 of the new burst appear in the very next cycle, with no idle cycle between the bursts.
- R10: A start seen while a beat other than the final one is shown is ignored. The current burst goes on unchanged and no extra beats follow it.
- R11: A burst keeps the length and order stored when it was accepted. A mode write during a burst takes effect from the next burst.
- R12: When start is accepted at an edge, beat 0 (col_out = start_col) is shown from that edge. Each later edge advances the burst by one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Stores mode_len_code and mode_order |
| mode_len_code | input | 3 | Burst length code (001/010/011 = 2/4/8 beats) |
| mode_order | input | 1 | 0 = sequential, 1 = interleaved |
| start | input | 1 | Burst start request |
| start_col | input | 10 | Starting column of the burst |
| term | input | 1 | Ends the running burst |
| col_out | output | 10 | Column address of the current beat, 0 when idle |
| beat_valid | output | 1 | col_out holds a beat |
| beat_last | output | 1 | Current beat is the final beat of the burst |
| mode_err | output | 1 | Stored length code is reserved |

## Verification
Beat 0 shows on the edge that takes the start, and beat i shows i edges after it. mode_err changes on the edge that stores the mode word, and beat_valid falls on the edge that samples term. The bench changes inputs just after a rising edge and reads outputs on the falling edge. A scoreboard queue holds one expected column and last flag per beat and is compared beat by beat. Explicit checks cover the cycle right after a start, a terminate, a chained start and an error.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
    import bcs_pkg::*;
#(
    parameter int LEN_CODE_W = 3,
    parameter int MAX_LOG2   = 3,
    parameter int LOG_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  order_i,
    output logic [LOG_W-1:0]      log2_o,
    output order_e                order_o,
    output logic                  err_o
);

    localparam logic [LEN_CODE_W-1:0] CODE_ONE   = LEN_CODE_W'(1);
    localparam logic [LEN_CODE_W-1:0] CODE_MAX   = LEN_CODE_W'(MAX_LOG2);
    localparam logic [LEN_CODE_W-1:0] CODE_RESET = CODE_ONE;

    typedef struct packed {
        logic [LEN_CODE_W-1:0] code;
        order_e                order;
    } mode_t;

    mode_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_i) begin
            m_d.code  = code_i;
            m_d.order = order_e'(order_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '{code: CODE_RESET, order: ORD_SEQ};
        end else begin
            m_q <= m_d;
        end
    end

    assign err_o   = !((m_q.code >= CODE_ONE) && (m_q.code <= CODE_MAX));
    assign log2_o  = m_q.code[LOG_W-1:0];
    assign order_o = m_q.order;

endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int IDX_W = 3,
    parameter int LOG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [LOG_W-1:0] log2_i,
    input  order_e           order_i,
    input  logic             err_i,
    output logic             busy_o,
    output logic             last_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [LOG_W-1:0] log2_o,
    output order_e           order_o,
    output logic [COL_W-1:0] col_o
);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [LOG_W-1:0] log2;
        order_e           order;
        logic [COL_W-1:0] col;
    } beat_t;

    beat_t            st_d, st_q;
    logic [IDX_W-1:0] last_idx;
    logic             is_last;
    logic             accept;

    always_comb begin
        for (int b = 0; b < IDX_W; b++) begin
            last_idx[b] = (LOG_W'(b) < st_q.log2);
        end
    end

    assign is_last = st_q.busy && (st_q.idx == last_idx);
    assign accept  = start_i && !err_i && (!st_q.busy || is_last);

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.log2  = log2_i;
            st_d.order = order_i;
            st_d.col   = start_col_i;
        end else if (st_q.busy && (term_i || is_last)) begin
            st_d.busy = 1'b0;
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, idx: '0, log2: '0, order: ORD_SEQ, col: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign last_o  = is_last;
    assign idx_o   = st_q.idx;
    assign log2_o  = st_q.log2;
    assign order_o = st_q.order;
    assign col_o   = st_q.col;

endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W    = 10,
    parameter int MAX_LOG2 = 3,
    parameter int LOG_W    = 2
) (
    input  logic [COL_W-1:0]    start_col_i,
    input  logic [MAX_LOG2-1:0] idx_i,
    input  logic [LOG_W-1:0]    log2_i,
    input  order_e              order_i,
    output logic [COL_W-1:0]    col_o
);

    localparam int LOW_W = MAX_LOG2;

    logic [LOW_W-1:0] seq_off;
    logic [LOW_W-1:0] intlv_off;
    logic [LOW_W-1:0] pick_off;

    assign seq_off   = start_col_i[LOW_W-1:0] + idx_i;
    assign intlv_off = start_col_i[LOW_W-1:0] ^ idx_i;
    assign pick_off  = (order_i == ORD_INTLV) ? intlv_off : seq_off;

    for (genvar b = 0; b < LOW_W; b++) begin : g_low
        localparam logic [LOG_W-1:0] BIT_POS = LOG_W'(b);
        assign col_o[b] = (BIT_POS < log2_i) ? pick_off[b] : start_col_i[b];
    end

    if (COL_W > LOW_W) begin : g_high
        assign col_o[COL_W-1:LOW_W] = start_col_i[COL_W-1:LOW_W];
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int LEN_CODE_W = 3,
    parameter int MAX_LOG2   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_wr,
    input  logic [LEN_CODE_W-1:0] mode_len_code,
    input  logic                  mode_order,
    input  logic                  start,
    input  logic [COL_W-1:0]      start_col,
    input  logic                  term,
    output logic [COL_W-1:0]      col_out,
    output logic                  beat_valid,
    output logic                  beat_last,
    output logic                  mode_err
);

    localparam int LOG_W = $clog2(MAX_LOG2 + 1);

    logic [LOG_W-1:0]    cfg_log2;
    order_e              cfg_order;
    logic                cfg_err;
    logic                busy;
    logic                last;
    logic [MAX_LOG2-1:0] idx;
    logic [LOG_W-1:0]    cur_log2;
    order_e              cur_order;
    logic [COL_W-1:0]    cur_col;
    logic [COL_W-1:0]    beat_col;

    bcs_mode_reg #(
        .LEN_CODE_W(LEN_CODE_W),
        .MAX_LOG2  (MAX_LOG2),
        .LOG_W     (LOG_W)
    ) mode_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (mode_wr),
        .code_i (mode_len_code),
        .order_i(mode_order),
        .log2_o (cfg_log2),
        .order_o(cfg_order),
        .err_o  (cfg_err)
    );

    bcs_beat_ctrl #(
        .COL_W(COL_W),
        .IDX_W(MAX_LOG2),
        .LOG_W(LOG_W)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .term_i     (term),
        .start_col_i(start_col),
        .log2_i     (cfg_log2),
        .order_i    (cfg_order),
        .err_i      (cfg_err),
        .busy_o     (busy),
        .last_o     (last),
        .idx_o      (idx),
        .log2_o     (cur_log2),
        .order_o    (cur_order),
        .col_o      (cur_col)
    );

    bcs_addr_gen #(
        .COL_W   (COL_W),
        .MAX_LOG2(MAX_LOG2),
        .LOG_W   (LOG_W)
    ) addr_i (
        .start_col_i(cur_col),
        .idx_i      (idx),
        .log2_i     (cur_log2),
        .order_i    (cur_order),
        .col_o      (beat_col)
    );

    assign col_out    = busy ? beat_col : '0;
    assign beat_valid = busy;
    assign beat_last  = last;
    assign mode_err   = cfg_err;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int COL_W    = 10,
    parameter int MAX_LOG2 = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             term,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last,
    input logic             mode_err
);

    logic take;
    assign take = start && !mode_err && (!beat_valid || beat_last);

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid); // R7

    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last && !take |=> !beat_valid); // R7

    AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && term && !take |=> !beat_valid); // R8

    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err && !beat_valid |=> !beat_valid); // R3

    AST_START_GIVES_BEAT0: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> beat_valid && (col_out == $past(start_col))); // R12

    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_last && !term |=>
            beat_valid && $stable(col_out[COL_W-1:MAX_LOG2])); // R4

endmodule

bind burst_col_seq bcs_checker #(
    .COL_W   (COL_W),
    .MAX_LOG2(MAX_LOG2)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_col (start_col),
    .term      (term),
    .col_out   (col_out),
    .beat_valid(beat_valid),
    .beat_last (beat_last),
    .mode_err  (mode_err)
);

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_len_code = 3'b001;
    logic       mode_order = 1'b0;
    logic       start = 1'b0;
    logic [9:0] start_col = '0;
    logic       term = 1'b0;
    logic [9:0] col_out;
    logic       beat_valid;
    logic       beat_last;
    logic       mode_err;

    int n_chk = 0;
    int n_err = 0;

    logic [9:0] q_col[$];
    logic       q_last[$];
    string      q_tag[$];
    string      idle_tag = "R10";

    int m_log2 = 1;
    bit m_inter = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_len_code(mode_len_code),
        .mode_order   (mode_order),
        .start        (start),
        .start_col    (start_col),
        .term         (term),
        .col_out      (col_out),
        .beat_valid   (beat_valid),
        .beat_last    (beat_last),
        .mode_err     (mode_err)
    );

    function automatic logic [9:0] exp_col(int col, int lg, bit inter, int i);
        int mask;
        int off;
        mask = (1 << lg) - 1;
        off  = inter ? ((col & mask) ^ i) : ((col + i) & mask);
        return 10'((col & ~mask) | off);
    endfunction

    always @(negedge clk) begin
        if (rst_n && beat_valid) begin
            n_chk++;
            if (q_col.size() == 0) begin
                n_err++;
                $display("FAIL %s unexpected beat col=%0h last=%0b, expected no beat",
                         idle_tag, col_out, beat_last);
            end else begin
                logic [9:0] ec;
                logic       el;
                string      et;
                ec = q_col.pop_front();
                el = q_last.pop_front();
                et = q_tag.pop_front();
                if (col_out !== ec || beat_last !== el) begin
                    n_err++;
                    $display("FAIL %s col=%0h last=%0b expected col=%0h last=%0b",
                             et, col_out, beat_last, ec, el);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic [2:0] code, bit inter);
        mode_wr       = 1'b1;
        mode_len_code = code;
        mode_order    = inter;
        tick();
        mode_wr = 1'b0;
        if (code >= 3'd1 && code <= 3'd3) begin
            m_log2  = int'(code);
            m_inter = inter;
        end
    endtask

    task automatic issue(logic [9:0] col, string tag, bit expect_run);
        if (expect_run) begin
            for (int i = 0; i < (1 << m_log2); i++) begin
                q_col.push_back(exp_col(int'(col), m_log2, m_inter, i));
                q_last.push_back(i == (1 << m_log2) - 1);
                q_tag.push_back(tag);
            end
        end
        start     = 1'b1;
        start_col = col;
        tick();
        start = 1'b0;
    endtask

    task automatic drain(string tag);
        wait_cyc(12);
        check_eq({tag, " all beats seen"}, q_col.size(), 0);
        q_col.delete();
        q_last.delete();
        q_tag.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        check_eq("R1 valid", int'(beat_valid), 0);
        check_eq("R1 last", int'(beat_last), 0);
        check_eq("R1 err", int'(mode_err), 0);
        check_eq("R1 col", int'(col_out), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();

        // R1 R2 R12: default mode is 2 beats sequential
        issue(10'h155, "R1 R2 R5", 1'b1);
        @(negedge clk);
        check_eq("R12 beat0 valid", int'(beat_valid), 1);
        check_eq("R12 beat0 col", int'(col_out), 'h155);
        drain("R2");

        set_mode(3'b010, 1'b0);
        issue(10'h2B6, "R2 R4 R5 R7", 1'b1);
        drain("R2");

        set_mode(3'b011, 1'b0);
        issue(10'h3AD, "R2 R4 R5 R7", 1'b1);
        drain("R5");

        set_mode(3'b011, 1'b1);
        issue(10'h3AD, "R6 R4 R7", 1'b1);
        drain("R6");
        set_mode(3'b010, 1'b1);
        issue(10'h0C3, "R6", 1'b1);
        drain("R6");
        set_mode(3'b001, 1'b1);
        issue(10'h2F1, "R6", 1'b1);
        drain("R6");

        // R9 back to back bursts
        set_mode(3'b010, 1'b0);
        issue(10'h1F9, "R9 first", 1'b1);
        wait_cyc(3);
        issue(10'h20E, "R9 second", 1'b1);
        @(negedge clk);
        check_eq("R9 no gap valid", int'(beat_valid), 1);
        check_eq("R9 no gap col", int'(col_out), 'h20E);
        drain("R9");

        // R10 start in mid burst ignored
        idle_tag = "R10";
        issue(10'h100, "R10", 1'b1);
        wait_cyc(1);
        issue(10'h0FF, "R10", 1'b0);
        drain("R10");

        // R8 terminate
        set_mode(3'b011, 1'b0);
        idle_tag = "R8";
        issue(10'h046, "R8", 1'b1);
        wait_cyc(2);
        term = 1'b1;
        @(negedge clk);
        @(posedge clk);
        #1;
        term = 1'b0;
        q_col.delete();
        q_last.delete();
        q_tag.delete();
        @(negedge clk);
        check_eq("R8 valid after term", int'(beat_valid), 0);
        check_eq("R8 last after term", int'(beat_last), 0);
        drain("R8");

        // R11 mode write during burst
        set_mode(3'b010, 1'b0);
        idle_tag = "R11";
        issue(10'h020, "R11 old length", 1'b1);
        wait_cyc(1);
        set_mode(3'b011, 1'b0);
        drain("R11");
        issue(10'h02B, "R11 new length", 1'b1);
        drain("R11");

        // R3 reserved codes
        idle_tag = "R3";
        set_mode(3'b000, 1'b0);
        @(negedge clk);
        check_eq("R3 err code 000", int'(mode_err), 1);
        @(posedge clk);
        #1;
        issue(10'h011, "R3", 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_eq("R3 no burst while err", int'(beat_valid), 0);
        end
        @(posedge clk);
        #1;
        set_mode(3'b110, 1'b0);
        @(negedge clk);
        check_eq("R3 err code 110", int'(mode_err), 1);
        @(posedge clk);
        #1;
        set_mode(3'b001, 1'b0);
        @(negedge clk);
        check_eq("R3 err cleared", int'(mode_err), 0);
        @(posedge clk);
        #1;
        issue(10'h011, "R3 after valid code", 1'b1);
        drain("R3");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule